// File: doc/BRIEF.md
# Three-Sample Falling-Window Detector

This block watches a serial bit stream, taking one sample per rising clock edge. It flags every point where the sample from two clocks back was 1 and the present sample is 0. The middle sample does not matter, so the windows 100 and 110 (oldest sample first) both count as a match. Windows overlap: each new sample starts a fresh three-sample window, and nothing is cleared after a match.

Two flags are provided, and they differ only in timing. The immediate flag is a function of the stored history and the live input, so it rises in the same cycle as the closing 0. The registered flag comes from state bits alone, so it rises one clock after the immediate flag and holds steady for the whole cycle, whatever the input does. A synchronous active-low reset returns the block to an all-zero history.

Top module: `win_fall_detect`

## Requirements
- R1: `hit_now` is 1 in the cycle where the present `din` is 0 and the sample taken two rising edges earlier was 1, whatever the sample in between. This covers the windows 100 and 110, oldest sample first.
- R2: `hit_now` is 0 for the other six three-sample windows: 000, 001, 010, 011, 101 and 111.
- R3: `hit_reg` in each cycle equals the value `hit_now` had in the cycle before the most recent rising edge. After reset this earlier value counts as 0.
- R4: `hit_reg` does not depend on the present `din`. Changing `din` between two clock edges leaves `hit_reg` unchanged.
- R5: Matches overlap. The stream 1,1,1,0,0,0 gives `hit_now` = 0,0,0,1,1,0, because the windows 110 and 100 are back to back.
- R6: When `rst_n` is 0 at a rising edge, the history becomes all zeros and `hit_reg` becomes 0. No flag can rise before the third sample after reset, even if 1s were taken before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; samples are taken on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data sample |
| hit_now | output | 1 | Same-cycle match flag, driven from state and the live input |
| hit_reg | output | 1 | Registered match flag, one clock behind `hit_now` |

## Verification
The assertions take for granted that `din` is settled before each rising edge, and that `rst_n` is held low at time zero until the first edge, so the history has a known start. The window and quiet-after-reset properties use a small counter of samples taken since reset, so they look back only at samples that were actually taken. The stimulus changes `din` and `rst_n` only on falling edges. Between edges it briefly drives the inverse of each bit, which exposes any path from `din` into the registered flag.

// File: rtl/wfd_pkg.sv
// Package: wfd_pkg
// Shared state types for the three-sample falling-window detector.
// Assumes the window length is fixed at three samples.
package wfd_pkg;

    // History of the two most recent samples: bit 1 is the older one.
    typedef enum logic [1:0] {
        HS_00 = 2'b00,
        HS_01 = 2'b01,
        HS_10 = 2'b10,
        HS_11 = 2'b11
    } hist_e;

    // Registered-flag machine: the two most recent samples, plus
    // two extra states that record "match taken at the last edge".
    typedef enum logic [2:0] {
        RG_00  = 3'd0,
        RG_01  = 3'd1,
        RG_10  = 3'd2,
        RG_11  = 3'd3,
        RG_00H = 3'd4,
        RG_10H = 3'd5
    } reg_state_e;

endpackage

// File: rtl/wfd_now_fsm.sv
// Module: wfd_now_fsm
// Keeps the last two samples and raises hit_now in the same cycle when
// the older stored sample is 1 and the live input is 0.
// Assumes din is settled before each rising edge; rst_n is synchronous.
module wfd_now_fsm
    import wfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit_now
);

    hist_e state_q;
    hist_e state_d;

    // Next history: shift in the present sample; unknown codes go home.
    always_comb begin
        case (state_q)
            HS_00:   state_d = din ? HS_01 : HS_00;
            HS_01:   state_d = din ? HS_11 : HS_10;
            HS_10:   state_d = din ? HS_01 : HS_00;
            HS_11:   state_d = din ? HS_11 : HS_10;
            default: state_d = HS_00;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_00;
        else        state_q <= state_d;
    end

    // Same-cycle flag: older sample 1 and live sample 0.
    always_comb begin
        case (state_q)
            HS_10, HS_11: hit_now = ~din;
            default:      hit_now = 1'b0;
        endcase
    end

    // R2: a live 1 can never close a match.
    p_one_never_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        din |-> !hit_now);

endmodule

// File: rtl/wfd_reg_fsm.sv
// Module: wfd_reg_fsm
// Six-state machine whose flag is decoded from state bits only; the
// two "H" states are entered on the edge that closes a match.
// Assumes din is settled before each rising edge; rst_n is synchronous.
module wfd_reg_fsm
    import wfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit_reg
);

    reg_state_e state_q;
    reg_state_e state_d;

    // Next state: track last two samples and record a closing match.
    always_comb begin
        case (state_q)
            RG_00, RG_00H: state_d = din ? RG_01 : RG_00;
            RG_01:         state_d = din ? RG_11 : RG_10;
            RG_10, RG_10H: state_d = din ? RG_01 : RG_00H;
            RG_11:         state_d = din ? RG_11 : RG_10H;
            default:       state_d = RG_00;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RG_00;
        else        state_q <= state_d;
    end

    // Flag decoded from the state alone.
    always_comb begin
        hit_reg = (state_q == RG_00H) || (state_q == RG_10H);
    end

    // R3: the registered flag only follows an edge that sampled a 0.
    p_flag_after_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_reg |-> !$past(din));

endmodule

// File: rtl/win_fall_detect.sv
// Module: win_fall_detect
// Top level: runs the same-cycle and registered detectors side by side
// on one serial input. Windows 100 and 110 (oldest first) match.
// Assumes a synchronous active-low reset held low at power-up.
module win_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit_now,
    output logic hit_reg
);

    // Same-cycle detector.
    wfd_now_fsm u_now (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .hit_now (hit_now)
    );

    // Registered detector.
    wfd_reg_fsm u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .hit_reg (hit_reg)
    );

    // Samples taken since reset, saturating at 2; used by the checks below.
    logic [1:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= 2'd0;
        else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end

    // R3: registered flag is the same-cycle flag one clock later.
    p_reg_follows_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_now |=> hit_reg);
    p_reg_quiet_after_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_now |=> !hit_reg);

    // R1: once the window is full, the flag matches x(t-2)=1 and x(t)=0.
    p_window_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2) |-> (hit_now == ($past(din, 2) && !din)));

    // R6: no flag before the third sample after reset.
    p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd2) |-> (!hit_now && !hit_reg));

endmodule

// File: tb/sim_win_fall_detect.sv
module sim_win_fall_detect;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic hit_now;
    logic hit_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] hist = 2'b00;   // reference: bit 1 is the older sample
    logic prev_now = 1'b0;      // reference: expected hit_reg
    logic last_now = 1'b0;

    always #10 clk = ~clk;      // 50 MHz

    win_fall_detect u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .hit_now (hit_now),
        .hit_reg (hit_reg)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Reset for one edge, then confirm quiet outputs (R6).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b0;
        @(posedge clk);
        hist = 2'b00;
        prev_now = 1'b0;
        @(negedge clk);
        #1;
        check(hit_reg, 1'b0, "R6 reg after reset");
        check(hit_now, 1'b0, "R6 now after reset");
        rst_n = 1'b1;
    endtask

    // Drive one sample; check both flags against the reference.
    task automatic step(input logic v);
        logic reg_alt;
        logic exp_now;
        @(negedge clk);
        din = ~v;
        #1 reg_alt = hit_reg;
        din = v;
        #1;
        exp_now = hist[1] & ~v;
        check(hit_now, exp_now, exp_now ? "R1 window 1x0" : "R2 non-matching window");
        check(hit_reg, prev_now, "R3 one-clock lag");
        check(hit_reg, reg_alt, "R4 registered flag ignores din");
        last_now = hit_now;
        @(posedge clk);
        prev_now = exp_now;
        hist = {hist[0], v};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] r5_exp;
        repeat (2) @(posedge clk);
        do_reset();

        // R5: overlapping windows 110 then 100.
        r5_exp = 6'b000110;
        for (int i = 5; i >= 0; i--) begin
            step((i >= 3) ? 1'b1 : 1'b0);
            check(last_now, r5_exp[i], "R5 overlapping matches");
        end

        // R6: samples taken before reset must not produce a match after it.
        step(1'b1);
        step(1'b1);
        do_reset();
        step(1'b0);
        check(last_now, 1'b0, "R6 history cleared (first)");
        step(1'b0);
        check(last_now, 1'b0, "R6 history cleared (second)");

        // Exhaustive sweep of every 10-sample stream from reset (R1..R4).
        for (int s = 0; s < 1024; s++) begin
            do_reset();
            for (int i = 9; i >= 0; i--) step(s[i] ? 1'b1 : 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule